// File: doc/BRIEF.md
# DMA Channel Address and Count Unit

This unit keeps the transfer parameters for four DMA channels: a 16-bit memory address and a 16-bit count word. The top two bits of the count word give the transfer kind and the low 14 bits give the number of remaining cycles. Software writes these registers through an address/data/write-strobe port. A bus engine outside the unit issues one `step` pulse per transfer and names the active channel on `step_ch`. The unit shows that channel's current address, count and kind without a clock delay. In the following cycle it advances the address and decrements the count.

To move N bytes, software loads N-1. The transfer in which the count field is zero is the last one, and the unit raises a terminal-count flag during it. A mark flag is raised during every transfer that is a whole multiple of 128 transfers before the end of the block, and this includes the last transfer. A status word collects one sticky terminal-count bit per channel, plus an update flag that belongs to the auto-reload feature.

When auto-reload is on and channel 2 finishes, the update flag is set. The next step on channel 2 is then an update cycle. In that cycle nothing is transferred, and channel 2 takes a copy of channel 3's address and count word. Bus timing and channel arbitration belong to the surrounding engine.

Top module: `dma_addr_count_unit`

## Requirements
- R1: A write with `wr_addr[3]`=0 targets channel `wr_addr[2:1]`. `wr_addr[0]`=0 loads the 16-bit address and `wr_addr[0]`=1 loads the count word (bits 15:14 kind, bits 13:0 count). The stored values appear on `cur_addr`, `cur_type` and `cur_cnt` whenever `step_ch` selects that channel.
- R2: Each transfer step adds 1 to the selected channel's address (modulo 2^16) and subtracts 1 from its count field (modulo 2^14). The new values are visible from the next cycle.
- R3: `tc_o` is high during a transfer step whose count field is 0, and it is low at all other times.
- R4: `mark_o` is high during a transfer step whose count field has its low 7 bits all zero, so it occurs every 128 transfers counted back from the last transfer, including the last one.
- R5: `cur_type` reports count-word bits 15:14, and transfers never change them.
- R6: `stat_o[i]` (i = 0..3) is set in the cycle after channel i signals terminal count. It stays set until a cycle with `rd_stat` high clears all four bits. If a terminal count and a read occur in the same cycle, the new bit is kept.
- R7: A write with `wr_addr[3]`=1 sets auto-reload from `wr_data[0]`. With auto-reload on, a terminal count on channel 2 sets `stat_o[4]`. The next step on channel 2 is then an update cycle: `upd_cyc_o` is high, `tc_o` and `mark_o` are low, there is no advance, channel 2 loads channel 3's address and count word, and `stat_o[4]` clears.
- R8: `rd_stat` never clears `stat_o[4]`.
- R9: `rst` clears every channel register, the status word and the auto-reload setting.
- R10: A step changes only the selected channel. A register write in the same cycle as a step on the same register takes priority over the advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register select: bit 3 mode, bits 2:1 channel, bit 0 address/count |
| wr_data | input | 16 | Write data |
| rd_stat | input | 1 | Status read strobe, clears the terminal-count bits |
| step | input | 1 | One pulse per transfer or update cycle |
| step_ch | input | 2 | Selected channel |
| cur_addr | output | 16 | Address of selected channel |
| cur_cnt | output | 14 | Count field of selected channel |
| cur_type | output | 2 | Transfer kind of selected channel |
| tc_o | output | 1 | Terminal count during this transfer |
| mark_o | output | 1 | 128-cycle mark during this transfer |
| upd_cyc_o | output | 1 | This step is an auto-reload update cycle |
| stat_o | output | 5 | {update flag, terminal-count bits 3..0} |

## Verification
A corrupted address or count register appears on `cur_addr` or `cur_cnt` as soon as `step_ch` selects that channel, with no added delay. A count that is off by one moves `tc_o` and `mark_o` one transfer away from where the arithmetic expects them. Errors in the status path show up one cycle after the step or read that caused them. A wrong reload copy appears on channel 2's outputs in the cycle after the update cycle. For this reason the bench compares every output on every cycle, and it also scans all four channels with `step` low.

// File: rtl/dma_acu_pkg.sv
package dma_acu_pkg;
  localparam int unsigned ADDR_W    = 16;
  localparam int unsigned CNT_W     = 14;
  localparam int unsigned KIND_W    = 2;
  localparam int unsigned MARK_BITS = 7;

  // next address after a transfer (wraps)
  function automatic logic [ADDR_W-1:0] addr_next(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  // remaining count after a transfer (wraps)
  function automatic logic [CNT_W-1:0] cnt_next(input logic [CNT_W-1:0] c);
    return c - CNT_W'(1);
  endfunction

  // count field zero: this transfer is the last one
  function automatic logic cnt_is_last(input logic [CNT_W-1:0] c);
    return c == '0;
  endfunction

  // distance to end is a whole multiple of the mark block
  function automatic logic cnt_at_mark(input logic [CNT_W-1:0] c);
    return c[MARK_BITS-1:0] == '0;
  endfunction
endpackage

// File: rtl/dma_acu_chan.sv
module dma_acu_chan
  import dma_acu_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned CW = CNT_W,
  parameter int unsigned TW = KIND_W,
  localparam int unsigned CRW = TW + CW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ld_addr,
  input  logic           ld_cnt,
  input  logic [AW-1:0]  wdata,
  input  logic           adv,
  input  logic           reload,
  input  logic [AW-1:0]  rl_addr,
  input  logic [CRW-1:0] rl_cnt,
  output logic [AW-1:0]  addr_q,
  output logic [CRW-1:0] cnt_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
    end else if (ld_addr) begin
      addr_q <= wdata;
    end else if (reload) begin
      addr_q <= rl_addr;
    end else if (adv) begin
      addr_q <= addr_next(addr_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (ld_cnt) begin
      cnt_q <= wdata[CRW-1:0];
    end else if (reload) begin
      cnt_q <= rl_cnt;
    end else if (adv) begin
      cnt_q <= {cnt_q[CRW-1:CW], cnt_next(cnt_q[CW-1:0])};
    end
  end
endmodule

// File: rtl/dma_acu_status.sv
module dma_acu_status #(
  parameter int unsigned NCH = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] tc_set,
  input  logic           rd_clr,
  input  logic           upd_set,
  input  logic           upd_clr,
  output logic [NCH-1:0] tc_q,
  output logic           upd_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tc_q <= '0;
    end else begin
      tc_q <= (tc_q & ~{NCH{rd_clr}}) | tc_set;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      upd_q <= 1'b0;
    end else if (upd_clr) begin
      upd_q <= 1'b0;
    end else if (upd_set) begin
      upd_q <= 1'b1;
    end
  end
endmodule

// File: rtl/dma_acu_sel.sv
module dma_acu_sel #(
  parameter int unsigned NCH = 4,
  parameter int unsigned AW  = 16,
  parameter int unsigned CRW = 16,
  localparam int unsigned CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0][AW-1:0]  ch_addr,
  input  logic [NCH-1:0][CRW-1:0] ch_cnt,
  input  logic [CHW-1:0]          sel,
  output logic [AW-1:0]           addr_o,
  output logic [CRW-1:0]          cnt_o
);
  always_comb begin
    addr_o = '0;
    cnt_o  = '0;
    for (int i = 0; i < NCH; i++) begin
      if (sel == CHW'(i)) begin
        addr_o = ch_addr[i];
        cnt_o  = ch_cnt[i];
      end
    end
  end
endmodule

// File: rtl/dma_addr_count_unit.sv
module dma_addr_count_unit
  import dma_acu_pkg::*;
#(
  parameter int unsigned NCH    = 4,
  parameter int unsigned AW     = ADDR_W,
  parameter int unsigned CW     = CNT_W,
  parameter int unsigned TW     = KIND_W,
  parameter int unsigned RL_DST = 2,
  parameter int unsigned RL_SRC = 3,
  localparam int unsigned CHW   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int unsigned CRW   = TW + CW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [CHW+1:0] wr_addr,
  input  logic [AW-1:0]  wr_data,
  input  logic           rd_stat,
  input  logic           step,
  input  logic [CHW-1:0] step_ch,
  output logic [AW-1:0]  cur_addr,
  output logic [CW-1:0]  cur_cnt,
  output logic [TW-1:0]  cur_type,
  output logic           tc_o,
  output logic           mark_o,
  output logic           upd_cyc_o,
  output logic [NCH:0]   stat_o
);
  // register select decode
  logic           wr_mode;
  logic           wr_chan;
  logic [CHW-1:0] wr_ch;
  logic           wr_is_cnt;

  assign wr_mode   = wr_en &  wr_addr[CHW+1];
  assign wr_chan   = wr_en & ~wr_addr[CHW+1];
  assign wr_ch     = wr_addr[CHW:1];
  assign wr_is_cnt = wr_addr[0];

  // auto-reload enable
  logic reload_en;
  always_ff @(posedge clk) begin
    if (rst) begin
      reload_en <= 1'b0;
    end else if (wr_mode) begin
      reload_en <= wr_data[0];
    end
  end

  // channel storage
  logic [NCH-1:0][AW-1:0]  ch_addr;
  logic [NCH-1:0][CRW-1:0] ch_cnt;
  logic [AW-1:0]           sel_addr;
  logic [CRW-1:0]          sel_cnt;

  // named internal events
  logic           upd_q;
  logic           upd_cycle;
  logic           xfer;
  logic           tc_hit;
  logic           mark_hit;
  logic [NCH-1:0] tc_set;
  logic           upd_set;
  logic [NCH-1:0] tc_q;

  dma_acu_sel #(.NCH(NCH), .AW(AW), .CRW(CRW)) u_sel (
    .ch_addr (ch_addr),
    .ch_cnt  (ch_cnt),
    .sel     (step_ch),
    .addr_o  (sel_addr),
    .cnt_o   (sel_cnt)
  );

  assign upd_cycle = step & upd_q & (step_ch == CHW'(RL_DST));
  assign xfer      = step & ~upd_cycle;
  assign tc_hit    = xfer & cnt_is_last(sel_cnt[CW-1:0]);
  assign mark_hit  = xfer & cnt_at_mark(sel_cnt[CW-1:0]);
  assign upd_set   = tc_hit & reload_en & (step_ch == CHW'(RL_DST));

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic ld_a, ld_c, adv_g, rl_g;
    assign ld_a  = wr_chan & (wr_ch == CHW'(g)) & ~wr_is_cnt;
    assign ld_c  = wr_chan & (wr_ch == CHW'(g)) &  wr_is_cnt;
    assign adv_g = xfer & (step_ch == CHW'(g));
    assign tc_set[g] = tc_hit & (step_ch == CHW'(g));
    if (g == RL_DST) begin : g_rl
      assign rl_g = upd_cycle;
    end else begin : g_norl
      assign rl_g = 1'b0;
    end

    dma_acu_chan #(.AW(AW), .CW(CW), .TW(TW)) u_chan (
      .clk     (clk),
      .rst     (rst),
      .ld_addr (ld_a),
      .ld_cnt  (ld_c),
      .wdata   (wr_data),
      .adv     (adv_g),
      .reload  (rl_g),
      .rl_addr (ch_addr[RL_SRC]),
      .rl_cnt  (ch_cnt[RL_SRC]),
      .addr_q  (ch_addr[g]),
      .cnt_q   (ch_cnt[g])
    );
  end

  dma_acu_status #(.NCH(NCH)) u_stat (
    .clk     (clk),
    .rst     (rst),
    .tc_set  (tc_set),
    .rd_clr  (rd_stat),
    .upd_set (upd_set),
    .upd_clr (upd_cycle),
    .tc_q    (tc_q),
    .upd_q   (upd_q)
  );

  assign cur_addr  = sel_addr;
  assign cur_cnt   = sel_cnt[CW-1:0];
  assign cur_type  = sel_cnt[CRW-1:CW];
  assign tc_o      = tc_hit;
  assign mark_o    = mark_hit;
  assign upd_cyc_o = upd_cycle;
  assign stat_o    = {upd_q, tc_q};
endmodule

// File: rtl/dma_acu_chk.sv
module dma_acu_chk #(
  parameter int unsigned NCH    = 4,
  parameter int unsigned AW     = 16,
  parameter int unsigned CW     = 14,
  parameter int unsigned TW     = 2,
  parameter int unsigned RL_DST = 2,
  parameter int unsigned RL_SRC = 3,
  localparam int unsigned CHW   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int unsigned CRW   = TW + CW
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    wr_en,
  input logic                    rd_stat,
  input logic                    step,
  input logic [CHW-1:0]          step_ch,
  input logic                    xfer,
  input logic [AW-1:0]           cur_addr,
  input logic [CW-1:0]           cur_cnt,
  input logic [TW-1:0]           cur_type,
  input logic                    tc_o,
  input logic                    mark_o,
  input logic                    upd_cyc_o,
  input logic [NCH:0]            stat_o,
  input logic [NCH-1:0][AW-1:0]  ch_addr,
  input logic [NCH-1:0][CRW-1:0] ch_cnt
);
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    xfer && !wr_en |=> ch_addr[$past(step_ch)] == AW'($past(cur_addr) + 1)); // R2
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    xfer && !wr_en |=> ch_cnt[$past(step_ch)][CW-1:0] == CW'($past(cur_cnt) - 1)); // R2
  AST_KIND_KEEP: assert property (@(posedge clk) disable iff (rst)
    xfer && !wr_en |=> ch_cnt[$past(step_ch)][CRW-1:CW] == $past(cur_type)); // R5
  AST_TC_IS_MARK: assert property (@(posedge clk) disable iff (rst)
    tc_o |-> mark_o); // R4
  AST_TC_LATCH: assert property (@(posedge clk) disable iff (rst)
    tc_o |=> stat_o[$past(step_ch)]); // R6
  AST_RD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    rd_stat && !tc_o |=> stat_o[NCH-1:0] == '0); // R6
  AST_UPD_PERSIST: assert property (@(posedge clk) disable iff (rst)
    stat_o[NCH] && !upd_cyc_o |=> stat_o[NCH]); // R8
  AST_UPD_DONE: assert property (@(posedge clk) disable iff (rst)
    upd_cyc_o |=> !stat_o[NCH]); // R7
  AST_RELOAD_COPY: assert property (@(posedge clk) disable iff (rst)
    upd_cyc_o && !wr_en |=> ch_addr[RL_DST] == $past(ch_addr[RL_SRC])
                         && ch_cnt[RL_DST] == $past(ch_cnt[RL_SRC])); // R7

  for (genvar g = 0; g < NCH; g++) begin : g_hold
    AST_OTHER_HOLD: assert property (@(posedge clk) disable iff (rst)
      step && (step_ch != CHW'(g)) && !wr_en |=> $stable(ch_addr[g]) && $stable(ch_cnt[g])); // R10
  end
endmodule

bind dma_addr_count_unit dma_acu_chk #(
  .NCH(NCH), .AW(AW), .CW(CW), .TW(TW), .RL_DST(RL_DST), .RL_SRC(RL_SRC)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .rd_stat   (rd_stat),
  .step      (step),
  .step_ch   (step_ch),
  .xfer      (xfer),
  .cur_addr  (cur_addr),
  .cur_cnt   (cur_cnt),
  .cur_type  (cur_type),
  .tc_o      (tc_o),
  .mark_o    (mark_o),
  .upd_cyc_o (upd_cyc_o),
  .stat_o    (stat_o),
  .ch_addr   (ch_addr),
  .ch_cnt    (ch_cnt)
);

// File: tb/dma_addr_count_unit_test.sv
`timescale 1ns/1ps
module dma_addr_count_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        rd_stat = 1'b0;
  logic        step = 1'b0;
  logic [1:0]  step_ch = '0;
  logic [15:0] cur_addr;
  logic [13:0] cur_cnt;
  logic [1:0]  cur_type;
  logic        tc_o, mark_o, upd_cyc_o;
  logic [4:0]  stat_o;

  always #2.5 clk = ~clk;

  dma_addr_count_unit uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_stat(rd_stat), .step(step), .step_ch(step_ch), .cur_addr(cur_addr),
    .cur_cnt(cur_cnt), .cur_type(cur_type), .tc_o(tc_o), .mark_o(mark_o),
    .upd_cyc_o(upd_cyc_o), .stat_o(stat_o)
  );

  // reference state
  logic [15:0] m_addr [4];
  logic [13:0] m_cnt  [4];
  logic [1:0]  m_kind [4];
  logic [3:0]  m_tc;
  logic        m_upd, m_mode;
  int          vecs = 0, errs = 0;
  bit          done = 0;
  string       phase = "R9 reset";

  task automatic chk(input string f, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s act=%0h exp=%0h", phase, f, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 4; i++) begin
      m_addr[i] = '0; m_cnt[i] = '0; m_kind[i] = '0;
    end
    m_tc = '0; m_upd = 0; m_mode = 0;
  endtask

  // one cycle: drive at negedge, check, clock, update model
  task automatic tick(input bit st, input int ch, input bit rd,
                      input bit we, input logic [3:0] wa, input logic [15:0] wd);
    bit e_upd, e_x;
    logic [13:0] c;
    step = st; step_ch = 2'(ch); rd_stat = rd; wr_en = we; wr_addr = wa; wr_data = wd;
    #1;
    c     = m_cnt[ch];
    e_upd = st && m_upd && (ch == 2);
    e_x   = st && !e_upd;
    chk("cur_addr R1", 32'(cur_addr), 32'(m_addr[ch]));
    chk("cur_cnt R2", 32'(cur_cnt), 32'(c));
    chk("cur_type R5", 32'(cur_type), 32'(m_kind[ch]));
    chk("tc_o R3", 32'(tc_o), 32'(e_x && c == 0));
    chk("mark_o R4", 32'(mark_o), 32'(e_x && (c % 128) == 0));
    chk("upd_cyc_o R7", 32'(upd_cyc_o), 32'(e_upd));
    chk("stat_o R6", 32'(stat_o), 32'({m_upd, m_tc}));
    @(posedge clk);
    if (e_upd) begin
      m_addr[2] = m_addr[3]; m_cnt[2] = m_cnt[3]; m_kind[2] = m_kind[3]; m_upd = 0;
    end
    if (rd) m_tc = '0;
    if (e_x) begin
      if (c == 0) begin
        m_tc[ch] = 1'b1;
        if (ch == 2 && m_mode) m_upd = 1;
      end
      m_addr[ch] = m_addr[ch] + 16'd1;
      m_cnt[ch]  = c - 14'd1;
    end
    if (we) begin
      if (wa[3]) m_mode = wd[0];
      else if (!wa[0]) m_addr[wa[2:1]] = wd;
      else begin
        m_cnt[wa[2:1]] = wd[13:0]; m_kind[wa[2:1]] = wd[15:14];
      end
    end
    @(negedge clk);
  endtask

  task automatic idle(); tick(0, 0, 0, 0, 4'h0, 16'h0); endtask
  task automatic wr(input logic [3:0] wa, input logic [15:0] wd); tick(0, 0, 0, 1, wa, wd); endtask
  task automatic stp(input int ch); tick(1, ch, 0, 0, 4'h0, 16'h0); endtask
  task automatic scan(); for (int i = 0; i < 4; i++) tick(0, i, 0, 0, 4'h0, 16'h0); endtask

  task automatic do_reset();
    rst = 1; step = 0; wr_en = 0; rd_stat = 0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rst = 0; model_clear();
  endtask

  initial begin
    logic [31:0] lf;
    model_clear();
    phase = "R9 reset";
    do_reset();
    scan();

    phase = "R1 load";
    for (int i = 0; i < 4; i++) begin
      wr(4'(i * 2), 16'(16'h1000 * (i + 1) + i));
      wr(4'(i * 2 + 1), {2'(i), 14'(100 + i)});
    end
    wr(4'h8, 16'h0001);
    scan();

    phase = "R9 reset after load";
    do_reset();
    scan();

    phase = "R2 R3 R4 R5 sweep";
    wr(4'h0, 16'h2000);
    wr(4'h1, {2'b10, 14'd299});
    for (int k = 0; k < 305; k++) stp(0);

    phase = "R6 status read";
    idle();
    tick(0, 0, 1, 0, 4'h0, 16'h0);
    idle();
    wr(4'h3, {2'b01, 14'd0});
    wr(4'h7, {2'b11, 14'd0});
    stp(3);
    phase = "R6 read with new tc";
    tick(1, 1, 1, 0, 4'h0, 16'h0);
    idle();

    phase = "R2 address wrap";
    wr(4'h6, 16'hFFFE);
    wr(4'h7, {2'b00, 14'd5});
    for (int k = 0; k < 4; k++) stp(3);
    scan();

    phase = "R10 write beats step";
    tick(1, 0, 0, 1, 4'h0, 16'h5555);
    tick(1, 0, 0, 1, 4'h1, {2'b01, 14'd3});
    scan();

    phase = "R7 reload";
    wr(4'h8, 16'h0001);
    wr(4'h6, 16'h4000);
    wr(4'h7, {2'b01, 14'd2});
    wr(4'h4, 16'h1000);
    wr(4'h5, {2'b00, 14'd1});
    stp(2); stp(2);
    phase = "R8 read keeps update flag";
    tick(0, 2, 1, 0, 4'h0, 16'h0);
    tick(1, 1, 1, 0, 4'h0, 16'h0);
    idle();
    phase = "R7 update cycle";
    stp(2);
    scan();
    for (int k = 0; k < 4; k++) stp(2);
    stp(2);
    wr(4'h8, 16'h0000);
    stp(2);
    scan();

    phase = "R10 mixed traffic";
    lf = 32'hACE1_2468;
    for (int k = 0; k < 3000; k++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      tick(lf[0] | lf[1], int'(lf[3:2]), lf[8:4] == 0, lf[13:9] == 0,
           lf[17:14], {lf[31:29], 6'd0, lf[24:18]});
    end
    scan();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      errs++;
      $display("FAIL watchdog expired in %s", phase);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule